// File: doc/BRIEF.md
# Dual-Region Trace Address Filter

This block sits beside one RAM and decides, for every bus access, whether that access should be written into a trace buffer. It holds two programmable address windows. Each window has a base address, a power-of-two size code, a master selector and a direction selector. An access that lands in a window and meets that window's master and direction selectors is a trace candidate.

A global invert flag swaps the sense of the windows. In that mode only accesses that miss both windows are traced. Both windows are then expected to carry the same master and direction selectors, and the selectors of window 1 are the ones applied. The block emits one registered push pulse per traced access, together with a one-bit tag that names the window responsible for the push. Where the windows overlap, window 1 takes priority, so an access in the shared range gives one push, not two.

Configuration inputs are treated as static while accesses flow. The buffer, the serial trace format and peripheral-space tracing belong to other blocks.

Top module: `trace_region_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trace_push` and `trace_tag` are 0 after that edge.
- R2: A size code `c` from 1 to 8 gives a window of 2^(c+7) bytes. The window starts at the base address with its low c+7 bits cleared, so the low base bits are ignored. Code 0, and every code above 8, disables the window.
- R3: The master selector of a window, `rgnN_any_master` (0 = CPU only, 1 = CPU and other masters), decides whether an access with `acc_other` = 1 may be traced by that window. An access with `acc_other` = 0 is always acceptable to the master selector.
- R4: The direction selector of a window, `rgnN_read_dir` (1 = reads, 0 = writes), must equal `acc_read` (1 = read, 0 = write) before that window can trace the access.
- R5: With `inv_mode` = 0, an access is traced when at least one window contains the address and also meets its own master and direction selectors. An access that qualifies in both windows gives exactly one push.
- R6: With `inv_mode` = 0, `trace_tag` is 1 only when window 2 qualifies and window 1 does not. Otherwise it is 0, so an overlap reports window 1. `trace_tag` is 0 whenever `trace_push` is 0.
- R7: With `inv_mode` = 1 and both windows enabled, an access is traced when it lies in neither window and meets the selectors of window 1. The tag is then 0.
- R8: With `inv_mode` = 1 and either window disabled (R2), no access is traced.
- R9: `trace_push` is 1 in the cycle after an edge at which `acc_valid` was 1 and the access qualified. It is never 1 after an edge at which `acc_valid` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_mode | input | 1 | 1 = trace accesses outside both windows |
| rgn1_base | input | 32 | Window 1 base address |
| rgn1_code | input | 4 | Window 1 size code |
| rgn1_any_master | input | 1 | Window 1: 1 = any master, 0 = CPU only |
| rgn1_read_dir | input | 1 | Window 1: 1 = trace reads, 0 = trace writes |
| rgn2_base | input | 32 | Window 2 base address |
| rgn2_code | input | 4 | Window 2 size code |
| rgn2_any_master | input | 1 | Window 2: 1 = any master, 0 = CPU only |
| rgn2_read_dir | input | 1 | Window 2: 1 = trace reads, 0 = trace writes |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_other | input | 1 | 1 = access from a master other than the CPU |
| acc_read | input | 1 | 1 = read, 0 = write |
| trace_push | output | 1 | One-cycle push into the trace buffer |
| trace_tag | output | 1 | 0 = window 1, 1 = window 2 |

## Verification
A fault in the size decode or the base masking moves a window edge. That shows up as a missing or extra push at the first swept address past the true boundary, one cycle after the access. A fault in the priority or the invert logic shows up as a wrong tag or as a double decision within the overlap sweep, again on the next cycle. The registered outputs are the only state, so any error appears at most one cycle after the access that caused it.

// File: rtl/trf_pkg.sv
// Shared constants and types for the dual-region trace filter.
// Assumes exactly two windows; window 1 (index 0) has tag priority.
package trf_pkg;
    localparam int NUM_RGN    = 2;
    localparam int SHIFT_BASE = 7;   // code c -> 2^(c+7) bytes
    localparam int CODE_MAX   = 8;   // largest enabled code

    typedef enum logic {
        TAG_RGN1 = 1'b0,
        TAG_RGN2 = 1'b1
    } rgn_tag_e;
endpackage

// File: rtl/trf_region_match.sv
// Address window compare for one region.
// Assumes ADDR_W is at least CODE_MAX + SHIFT_BASE bits wide.
module trf_region_match #(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    output logic              en,
    output logic              hit
);
    import trf_pkg::*;

    logic [ADDR_W-1:0] keep_mask;

    // Enable decode and upper-bit compare of the address against the base.
    always_comb begin
        en        = (code != '0) && (int'(code) <= CODE_MAX);
        keep_mask = {ADDR_W{1'b1}} << (int'(code) + SHIFT_BASE);
        hit       = en && (((addr ^ base) & keep_mask) == '0);
    end
endmodule

// File: rtl/trf_rights_check.sv
// Master and direction permission check for one region.
// Assumes acc_other = 1 marks a non-CPU master and acc_read = 1 marks a read.
module trf_rights_check (
    input  logic any_master,
    input  logic read_dir,
    input  logic acc_other,
    input  logic acc_read,
    output logic ok
);
    // Both selectors must agree with the access.
    always_comb begin
        ok = (any_master || !acc_other) && (read_dir == acc_read);
    end
endmodule

// File: rtl/trf_decide.sv
// Combines per-region hits and rights into one trace decision and tag.
// Assumes in invert mode both regions carry the same rights; region 1's are used.
module trf_decide
    import trf_pkg::*;
(
    input  logic               inv,
    input  logic [NUM_RGN-1:0] en,
    input  logic [NUM_RGN-1:0] hit,
    input  logic [NUM_RGN-1:0] ok,
    output logic               want,
    output rgn_tag_e           tag
);
    logic [NUM_RGN-1:0] qual;

    // Normal mode: any qualified region traces; region 1 wins the tag.
    // Invert mode: trace only a miss of every region, all regions enabled.
    always_comb begin
        qual = hit & ok;
        if (!inv) begin
            want = |qual;
            tag  = (qual[1] && !qual[0]) ? TAG_RGN2 : TAG_RGN1;
        end else begin
            want = (&en) && !(|hit) && ok[0];
            tag  = TAG_RGN1;
        end
    end
endmodule

// File: rtl/trace_region_filter.sv
// Top of the dual-region trace filter: one access in, one registered
// push and region tag out, one cycle later.
// Assumes configuration inputs are stable while accesses are presented.
module trace_region_filter
    import trf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_mode,
    input  logic [ADDR_W-1:0] rgn1_base,
    input  logic [CODE_W-1:0] rgn1_code,
    input  logic              rgn1_any_master,
    input  logic              rgn1_read_dir,
    input  logic [ADDR_W-1:0] rgn2_base,
    input  logic [CODE_W-1:0] rgn2_code,
    input  logic              rgn2_any_master,
    input  logic              rgn2_read_dir,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_other,
    input  logic              acc_read,
    output logic              trace_push,
    output logic              trace_tag
);
    logic [ADDR_W-1:0]  base_a [NUM_RGN];
    logic [CODE_W-1:0]  code_a [NUM_RGN];
    logic [NUM_RGN-1:0] any_a;
    logic [NUM_RGN-1:0] rdir_a;
    logic [NUM_RGN-1:0] en_v;
    logic [NUM_RGN-1:0] hit_v;
    logic [NUM_RGN-1:0] ok_v;
    logic               want;
    rgn_tag_e           tag_d;

    // Gather the flat configuration ports into per-region arrays.
    always_comb begin
        base_a[0] = rgn1_base;
        base_a[1] = rgn2_base;
        code_a[0] = rgn1_code;
        code_a[1] = rgn2_code;
        any_a     = {rgn2_any_master, rgn1_any_master};
        rdir_a    = {rgn2_read_dir, rgn1_read_dir};
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        trf_region_match #(
            .ADDR_W(ADDR_W),
            .CODE_W(CODE_W)
        ) match_i (
            .addr(acc_addr),
            .base(base_a[g]),
            .code(code_a[g]),
            .en  (en_v[g]),
            .hit (hit_v[g])
        );

        trf_rights_check rights_i (
            .any_master(any_a[g]),
            .read_dir  (rdir_a[g]),
            .acc_other (acc_other),
            .acc_read  (acc_read),
            .ok        (ok_v[g])
        );
    end

    trf_decide decide_i (
        .inv (inv_mode),
        .en  (en_v),
        .hit (hit_v),
        .ok  (ok_v),
        .want(want),
        .tag (tag_d)
    );

    // Register the push and its tag; tag is forced to 0 with no push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_push <= 1'b0;
            trace_tag  <= 1'b0;
        end else begin
            trace_push <= acc_valid && want;
            trace_tag  <= acc_valid && want && (tag_d == TAG_RGN2);
        end
    end
endmodule

// File: rtl/trf_checker.sv
// Property checker for trace_region_filter, attached by bind below.
// Assumes the configuration is stable across each access.
module trf_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_mode,
    input logic [CODE_W-1:0] rgn1_code,
    input logic [CODE_W-1:0] rgn2_code,
    input logic              rgn1_any_master,
    input logic              rgn2_any_master,
    input logic              rgn1_read_dir,
    input logic              rgn2_read_dir,
    input logic              acc_valid,
    input logic              acc_other,
    input logic              acc_read,
    input logic              trace_push,
    input logic              trace_tag
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!trace_push && !trace_tag)); // R1

    AST_NO_FOREIGN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_other && !rgn1_any_master && !rgn2_any_master) |-> !trace_push); // R3

    AST_NO_READ_WHEN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_read && !rgn1_read_dir && !rgn2_read_dir) |-> !trace_push); // R4

    AST_TAG_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        trace_tag |-> trace_push); // R6

    AST_INV_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_mode) |-> !trace_tag); // R7

    AST_INV_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_mode && (rgn1_code == '0 || rgn2_code == '0)) |-> !trace_push); // R8

    AST_PUSH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trace_push |-> $past(acc_valid)); // R9
endmodule

bind trace_region_filter trf_checker #(.CODE_W(CODE_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .inv_mode       (inv_mode),
    .rgn1_code      (rgn1_code),
    .rgn2_code      (rgn2_code),
    .rgn1_any_master(rgn1_any_master),
    .rgn2_any_master(rgn2_any_master),
    .rgn1_read_dir  (rgn1_read_dir),
    .rgn2_read_dir  (rgn2_read_dir),
    .acc_valid      (acc_valid),
    .acc_other      (acc_other),
    .acc_read       (acc_read),
    .trace_push     (trace_push),
    .trace_tag      (trace_tag)
);

// File: tb/trace_region_filter_tb_top.sv
`timescale 1ns/1ps
// Sweeps addresses in 64-byte steps across several window setups, for
// every master/direction pair, against an arithmetic model.
module trace_region_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_mode = 1'b0;
    logic [31:0] rgn1_base = '0, rgn2_base = '0;
    logic [3:0]  rgn1_code = '0, rgn2_code = '0;
    logic        rgn1_any_master = 1'b0, rgn2_any_master = 1'b0;
    logic        rgn1_read_dir = 1'b0, rgn2_read_dir = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_other = 1'b0, acc_read = 1'b0;
    logic        trace_push, trace_tag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trace_region_filter dut_i (
        .clk(clk), .rst_n(rst_n), .inv_mode(inv_mode),
        .rgn1_base(rgn1_base), .rgn1_code(rgn1_code),
        .rgn1_any_master(rgn1_any_master), .rgn1_read_dir(rgn1_read_dir),
        .rgn2_base(rgn2_base), .rgn2_code(rgn2_code),
        .rgn2_any_master(rgn2_any_master), .rgn2_read_dir(rgn2_read_dir),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_other(acc_other), .acc_read(acc_read),
        .trace_push(trace_push), .trace_tag(trace_tag)
    );

    function automatic bit in_window(longint a, longint b, int c);
        longint sz, lo;
        if (c < 1 || c > 8) return 1'b0;
        sz = longint'(1) << (c + 7);
        lo = (b / sz) * sz;
        return (a >= lo) && (a < lo + sz);
    endfunction

    // Returns {push, tag} expected for the current configuration.
    function automatic logic [1:0] model(logic [31:0] a, logic oth, logic rd, logic vld);
        bit in1, in2, ok1, ok2, q1, q2, en1, en2;
        in1 = in_window(longint'(a), longint'(rgn1_base), int'(rgn1_code));
        in2 = in_window(longint'(a), longint'(rgn2_base), int'(rgn2_code));
        ok1 = (rgn1_any_master || !oth) && (rgn1_read_dir == rd);
        ok2 = (rgn2_any_master || !oth) && (rgn2_read_dir == rd);
        en1 = rgn1_code >= 1 && rgn1_code <= 8;
        en2 = rgn2_code >= 1 && rgn2_code <= 8;
        if (!vld) return 2'b00;
        if (!inv_mode) begin
            q1 = in1 && ok1;
            q2 = in2 && ok2;
            return {q1 || q2, q2 && !q1};
        end
        return {en1 && en2 && !in1 && !in2 && ok1, 1'b0};
    endfunction

    task automatic compare(string req, logic [1:0] exp);
        checks++;
        if ({trace_push, trace_tag} !== exp) begin
            errors++;
            $display("FAIL %s addr=%h oth=%b rd=%b inv=%b push=%b tag=%b expected push=%b tag=%b",
                     req, acc_addr, acc_other, acc_read, inv_mode,
                     trace_push, trace_tag, exp[1], exp[0]);
        end
    endtask

    // Present one access at a falling edge, sample after the next rising edge.
    task automatic one_access(string req, logic [31:0] a, logic oth, logic rd, logic vld);
        logic [1:0] exp;
        @(negedge clk);
        acc_addr  = a;
        acc_other = oth;
        acc_read  = rd;
        acc_valid = vld;
        exp = model(a, oth, rd, vld);
        @(negedge clk);
        compare(req, exp);
        acc_valid = 1'b0;
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 256; i++) begin
            for (int m = 0; m < 4; m++) begin
                one_access(req, 32'h0800_0000 + 32'(i) * 32'h40, m[0], m[1], 1'b1);
            end
            if (i % 32 == 0) one_access("R9", 32'h0800_0000 + 32'(i) * 32'h40, 1'b0, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Example setup, driven while in reset with a matching access.
        rgn1_base = 32'h0800_1000; rgn1_code = 4'd3; rgn1_any_master = 1'b0; rgn1_read_dir = 1'b0;
        rgn2_base = 32'h0800_3800; rgn2_code = 4'd4; rgn2_any_master = 1'b1; rgn2_read_dir = 1'b0;
        acc_addr = 32'h0800_1000; acc_valid = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", 2'b00);
        acc_valid = 1'b0;
        rst_n = 1'b1;

        sweep("R5");

        // Reset in mid-run with a qualifying access present.
        @(negedge clk);
        rst_n = 1'b0; acc_addr = 32'h0800_3800; acc_other = 1'b1; acc_read = 1'b0; acc_valid = 1'b1;
        @(negedge clk);
        compare("R1", 2'b00);
        rst_n = 1'b1; acc_valid = 1'b0;

        // Overlap: window 2 inside window 1, window 2 base has low bits set.
        rgn1_base = 32'h0800_2000; rgn1_code = 4'd5; rgn1_any_master = 1'b0; rgn1_read_dir = 1'b0;
        rgn2_base = 32'h0800_28F0; rgn2_code = 4'd3; rgn2_any_master = 1'b1; rgn2_read_dir = 1'b0;
        sweep("R6");

        // Reads on window 1 from any master, a 32 kB CPU-write window 2.
        rgn1_base = 32'h0800_1400; rgn1_code = 4'd2; rgn1_any_master = 1'b1; rgn1_read_dir = 1'b1;
        rgn2_base = 32'h0800_0123; rgn2_code = 4'd8; rgn2_any_master = 1'b0; rgn2_read_dir = 1'b0;
        sweep("R3");
        rgn2_code = 4'd1; rgn2_base = 32'h0800_3F80;
        sweep("R4");

        // Disabled codes.
        rgn1_code = 4'd0; rgn2_code = 4'd9;
        sweep("R2");

        // Inverse mode, shared rights.
        inv_mode = 1'b1;
        rgn1_base = 32'h0800_1000; rgn1_code = 4'd3; rgn1_any_master = 1'b0; rgn1_read_dir = 1'b0;
        rgn2_base = 32'h0800_3800; rgn2_code = 4'd4; rgn2_any_master = 1'b0; rgn2_read_dir = 1'b0;
        sweep("R7");

        // Inverse mode with one window disabled.
        rgn2_code = 4'd0;
        sweep("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule